// File: doc/BRIEF.md
# Conditional Execution Block Sequencer

This block follows an If-Then construct in a simple in-order decoder. A block-opening instruction supplies a base condition, a length of one to four, and a then/else switch for each later slot. The sequencer then gives every instruction issued inside the block the condition it must obey. It tests that condition against the live N, Z, C and V flags and drives one execute-or-skip bit. It advances by one slot each time an instruction retires.

The remaining block state is an 8-bit word that is always visible, so exception entry can stack it. It can be loaded back. A load marked as an exception return resumes the block. Any other load is treated as a jump: it clears the state and raises a fault if it tried to land inside a block. The block also reports malformed block openings, block openings and compare-and-branch instructions met inside a block, and it holds still while the pipeline stalls.

Top module: `itblk_seq`

## Requirements
- R1: With `open_vld` high, `stall` low and no active block, a block of `open_len`+1 instructions (1 to 4) starts at the next clock. `in_blk` is then high for exactly that many issued instructions (`iss_vld` high, no stall) and falls at the clock on which the last one retires.
- R2: The first slot uses `open_cond`. Slot k (k = 2, 3, 4) uses `open_cond` when `open_else[k-2]` is 0 and `open_cond` with bit 0 inverted when it is 1. The condition of the current slot is driven on `cur_cond`.
- R3: If `open_cond` is 4'b1110 (always) and any `open_else` bit that belongs to a used slot is 1, `bad_open` is high in that cycle and no block starts. Else bits of unused slots are ignored.
- R4: Condition codes are EQ=0 (Z), NE=1, CS=2 (C), CC=3, MI=4 (N), PL=5, VS=6 (V), VC=7, HI=8 (C and not Z), LS=9, GE=10 (N==V), LT=11, GT=12 (not Z and N==V), LE=13, AL=14, and 15 also always passes. `flags` is {N,Z,C,V}. Inside a block `exec_ok` equals the result of `cur_cond`. Outside a block `exec_ok` is 1 and `cur_cond` is 4'b1110.
- R5: When `iss_bkpt` is high, `exec_ok` is 1 even if the condition fails.
- R6: `st_out` is the state {base[3:1], slot condition bit, 4-bit mask}. At each retire, the low five bits shift left by one, and the state clears when mask bits [2:0] are zero. A `st_load` with `st_exret` high loads `st_in` at the next clock and overrides stall and every other input.
- R7: A `st_load` with `st_exret` low clears the state at the next clock. It drives `bad_entry` high in that cycle when `st_in[3:0]` is non-zero.
- R8: Inside a block without stall, `open_vld`, or `iss_vld` with `iss_cbz`, drives `bad_nest` high in that cycle. An opening seen inside a block does not reload the state.
- R9: While `stall` is high and `st_load` is low, the state does not change and neither the opening flags nor `bad_nest` are raised.
- R10: While `rst_n` is low the state is zero, and it stays zero at the first clock after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| open_vld | input | 1 | Block-opening instruction retires this cycle |
| open_cond | input | 4 | Base condition of the block |
| open_len | input | 2 | Block length minus one |
| open_else | input | 3 | Else switches for slots 2..4 (bit 0 = slot 2) |
| iss_vld | input | 1 | Instruction issues/retires this cycle |
| iss_bkpt | input | 1 | Issued instruction is a breakpoint |
| iss_cbz | input | 1 | Issued instruction is compare-and-branch on zero/non-zero |
| stall | input | 1 | Pipeline stall, hold state |
| flags | input | 4 | {N,Z,C,V} condition flags |
| st_load | input | 1 | Load block state from `st_in` |
| st_exret | input | 1 | The load is an exception return |
| st_in | input | 8 | State to load |
| st_out | output | 8 | Current block state for stacking |
| in_blk | output | 1 | An instruction of a block is next |
| cur_cond | output | 4 | Condition for the current instruction |
| exec_ok | output | 1 | Execute (1) or skip (0) the issued instruction |
| bad_open | output | 1 | Malformed always-condition opening |
| bad_nest | output | 1 | Forbidden instruction inside a block |
| bad_entry | output | 1 | Jump into a block other than by exception return |

## Verification
`cur_cond`, `exec_ok`, `bad_open`, `bad_nest` and `bad_entry` are combinational on the current state and inputs, so they are due in the same cycle as the stimulus. The bench reads them one time unit after driving on the falling edge. `in_blk`, `st_out` and the slot condition move one clock after an opening, retire, stall or load. The bench therefore checks them at the next falling edge, after exactly one rising edge has passed. Block length is measured by counting issued instructions until `in_blk` falls.

// File: rtl/itblk_pkg.sv
// Shared constants and helpers for the conditional block sequencer.
// Assumes 4-bit condition codes and an 8-bit state word.
package itblk_pkg;
    localparam int CW     = 4;              // condition width
    localparam int MW     = 4;              // mask width
    localparam int SW     = CW + MW;        // state width
    localparam int MAXLEN = MW;             // slots per block
    localparam logic [CW-1:0] COND_AL = 4'b1110;

    typedef logic [SW-1:0] blk_state_t;

    // Current slot condition held in a state word.
    function automatic logic [CW-1:0] st_cond(input blk_state_t s);
        return s[SW-1:MW];
    endfunction

    // True while a block is active.
    function automatic logic st_active(input blk_state_t s);
        return |s[MW-1:0];
    endfunction
endpackage

// File: rtl/itblk_cond_eval.sv
// Evaluates a 4-bit condition code against {N,Z,C,V}.
// Assumes codes 14 and 15 both pass unconditionally.
module itblk_cond_eval
    import itblk_pkg::*;
(
    input  logic [CW-1:0] cond,
    input  logic [3:0]    nzcv,
    output logic          pass
);
    logic n, z, c, v, base;

    assign {n, z, c, v} = nzcv;

    // Select the base test from the upper three bits, then invert on bit 0.
    always_comb begin
        unique case (cond[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c & ~z;
            3'd5:    base = (n == v);
            3'd6:    base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        pass = (cond[3:1] == 3'd7) ? 1'b1 : (base ^ cond[0]);
    end
endmodule

// File: rtl/itblk_open_dec.sv
// Turns a block-opening request into its initial state word and flags a
// malformed always-condition opening. Assumes len is length minus one.
module itblk_open_dec
    import itblk_pkg::*;
(
    input  logic [CW-1:0]     cond,
    input  logic [1:0]        len,
    input  logic [MAXLEN-2:0] els,
    output blk_state_t        init,
    output logic              bad_al
);
    localparam int LW = MW + 1;    // slot bit plus mask

    logic [LW-1:0]     low;
    logic [MAXLEN-2:0] used;

    // Build the slot bits and the end marker for the requested length.
    always_comb begin
        low      = '0;
        low[LW-1] = cond[0];
        for (int i = 1; i < MAXLEN; i++) begin
            used[i-1] = (i <= int'(len));
            if (used[i-1]) low[LW-1-i] = cond[0] ^ els[i-1];
        end
        low[LW-2-int'(len)] = 1'b1;
        init   = {cond[CW-1:1], low};
        bad_al = (cond == COND_AL) && |(els & used);
    end
endmodule

// File: rtl/itblk_state_reg.sv
// Holds the block state word with priority load > stall > open > advance.
// Assumes control inputs are already qualified by the top module.
module itblk_state_reg
    import itblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic       ld_ok,
    input  blk_state_t ld_val,
    input  logic       hold,
    input  logic       open_take,
    input  blk_state_t open_val,
    input  logic       adv,
    output blk_state_t st_q
);
    // Update the state word once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                  st_q <= '0;
        else if (ld)                 st_q <= ld_ok ? ld_val : '0;
        else if (hold)               st_q <= st_q;
        else if (open_take)          st_q <= open_val;
        else if (adv) begin
            if (st_q[2:0] == 3'b000) st_q <= '0;
            else                     st_q <= {st_q[SW-1:MW+1], st_q[MW:0] << 1};
        end
    end
endmodule

// File: rtl/itblk_seq.sv
// Top of the conditional execution block sequencer: tracks the active
// block, drives per-instruction conditions and the execute bit, and flags
// illegal openings, nesting and entries. Assumes one issue per cycle.
module itblk_seq
    import itblk_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_vld,
    input  logic [3:0]    open_cond,
    input  logic [1:0]    open_len,
    input  logic [2:0]    open_else,
    input  logic          iss_vld,
    input  logic          iss_bkpt,
    input  logic          iss_cbz,
    input  logic          stall,
    input  logic [3:0]    flags,
    input  logic          st_load,
    input  logic          st_exret,
    input  logic [7:0]    st_in,
    output logic [7:0]    st_out,
    output logic          in_blk,
    output logic [3:0]    cur_cond,
    output logic          exec_ok,
    output logic          bad_open,
    output logic          bad_nest,
    output logic          bad_entry
);
    blk_state_t st_q, open_init;
    logic       al_bad, pass, open_take, adv;

    itblk_open_dec u_dec (
        .cond   (open_cond),
        .len    (open_len),
        .els    (open_else),
        .init   (open_init),
        .bad_al (al_bad)
    );

    itblk_cond_eval u_eval (
        .cond (cur_cond),
        .nzcv (flags),
        .pass (pass)
    );

    // Qualify opening and retire events.
    always_comb begin
        in_blk    = st_active(st_q);
        cur_cond  = in_blk ? st_cond(st_q) : COND_AL;
        open_take = open_vld & ~stall & ~in_blk & ~al_bad;
        adv       = iss_vld & ~stall & in_blk;
    end

    // Drive execute decision and fault flags.
    always_comb begin
        exec_ok   = ~in_blk | pass | iss_bkpt;
        bad_open  = open_vld & ~stall & ~in_blk & al_bad;
        bad_nest  = in_blk & ~stall & (open_vld | (iss_vld & iss_cbz));
        bad_entry = st_load & ~st_exret & (|st_in[3:0]);
    end

    itblk_state_reg u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (st_load),
        .ld_ok     (st_exret),
        .ld_val    (st_in),
        .hold      (stall),
        .open_take (open_take),
        .open_val  (open_init),
        .adv       (adv),
        .st_q      (st_q)
    );

    assign st_out = st_q;
endmodule

// File: rtl/itblk_seq_chk.sv
// Assertion checker for itblk_seq, attached with bind below.
module itblk_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       open_vld,
    input logic       iss_vld,
    input logic       iss_bkpt,
    input logic       iss_cbz,
    input logic       stall,
    input logic       st_load,
    input logic       st_exret,
    input logic [7:0] st_in,
    input logic [7:0] st_out,
    input logic       in_blk,
    input logic [3:0] cur_cond,
    input logic       exec_ok,
    input logic       bad_open,
    input logic       bad_nest,
    input logic       bad_entry
);
    AST_OUTSIDE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_blk |-> (exec_ok && cur_cond == 4'b1110)); // R4
    AST_BKPT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        iss_bkpt |-> exec_ok); // R5
    AST_BAD_OPEN_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_open && !st_load) |=> !in_blk); // R3
    AST_EXRET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_load && st_exret) |=> st_out == $past(st_in)); // R6
    AST_JUMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_load && !st_exret) |=> st_out == 8'h00); // R7
    AST_JUMP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_load && !st_exret && st_in[3:0] != 4'h0) |-> bad_entry); // R7
    AST_CBZ_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk && !stall && iss_vld && iss_cbz) |-> bad_nest); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !st_load) |=> $stable(st_out)); // R9
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !(bad_nest || bad_open)); // R9
    AST_RETIRE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blk && iss_vld && !stall && !st_load && st_out[2:0] != 3'b000)
        |=> st_out[4:0] == {$past(st_out[3:0]), 1'b0}); // R6
endmodule

bind itblk_seq itblk_seq_chk u_chk (.*);

// File: tb/sim_itblk_seq.sv
`timescale 1ns/1ps
module sim_itblk_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       open_vld = 0, iss_vld = 0, iss_bkpt = 0, iss_cbz = 0, stall = 0;
    logic [3:0] open_cond = 0, flags = 0;
    logic [1:0] open_len = 0;
    logic [2:0] open_else = 0;
    logic       st_load = 0, st_exret = 0;
    logic [7:0] st_in = 0, st_out;
    logic       in_blk, exec_ok, bad_open, bad_nest, bad_entry;
    logic [3:0] cur_cond;
    int         total = 0, bad = 0;
    logic [7:0] saved;

    always #5 clk = ~clk;

    itblk_seq u0 (.*);

    // {cond, NZCV, expected pass}
    localparam logic [8:0] TBL [17] = '{
        9'b0000_0100_1, 9'b0001_0100_0, 9'b0010_0010_1, 9'b0011_0010_0,
        9'b0100_1000_1, 9'b0101_1000_0, 9'b0110_0001_1, 9'b0111_0000_1,
        9'b1000_0010_1, 9'b1000_0110_0, 9'b1001_0110_1, 9'b1010_1001_1,
        9'b1011_1000_1, 9'b1100_0000_1, 9'b1100_0100_0, 9'b1101_1001_0,
        9'b1110_0000_1};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        open_vld = 0; iss_vld = 0; iss_bkpt = 0; iss_cbz = 0; stall = 0;
        st_load = 0; st_exret = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        quiet();
        #1;
    endtask

    task automatic open_blk(input logic [3:0] c, input logic [1:0] l, input logic [2:0] e);
        open_vld = 1; open_cond = c; open_len = l; open_else = e;
        tick();
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (2) @(negedge clk);
        #1;
        chk("R10 state in reset", st_out, 8'h00);
        chk("R4 exec outside block", {7'd0, exec_ok}, 8'd1);
        rst_n = 1'b1;
        tick();
        chk("R10 state after release", st_out, 8'h00);

        // R4 condition table, one single-slot block per entry
        for (int i = 0; i < 17; i++) begin
            open_blk(TBL[i][8:5], 2'd0, 3'd0);
            flags = TBL[i][4:1];
            #1;
            chk($sformatf("R4 cond %0d", i), {7'd0, exec_ok}, {7'd0, TBL[i][0]});
            chk("R2 slot1 base", {4'd0, cur_cond}, {4'd0, TBL[i][8:5]});
            iss_vld = 1;
            tick();
            chk("R1 len1 ends", {7'd0, in_blk}, 8'd0);
        end

        // R1/R2 four-slot block, EQ with else on slots 2 and 4
        flags = 4'b0100;
        open_blk(4'b0000, 2'd3, 3'b101);
        begin
            logic [3:0] ec [4] = '{4'b0000, 4'b0001, 4'b0000, 4'b0001};
            for (int k = 0; k < 4; k++) begin
                chk("R1 in block", {7'd0, in_blk}, 8'd1);
                chk("R2 slot cond", {4'd0, cur_cond}, {4'd0, ec[k]});
                chk("R4 slot exec", {7'd0, exec_ok}, {7'd0, ~ec[k][0]});
                iss_vld = 1;
                tick();
            end
        end
        chk("R1 len4 ends", {7'd0, in_blk}, 8'd0);

        // R2 NE base, slot2 else gives EQ
        open_blk(4'b0001, 2'd1, 3'b001);
        chk("R2 NE slot1", {4'd0, cur_cond}, 8'h01);
        iss_vld = 1; tick();
        chk("R2 NE slot2", {4'd0, cur_cond}, 8'h00);
        iss_vld = 1; tick();
        chk("R1 len2 ends", {7'd0, in_blk}, 8'd0);

        // R3 always-condition openings
        open_vld = 1; open_cond = 4'b1110; open_len = 2'd1; open_else = 3'b001;
        #1;
        chk("R3 bad_open", {7'd0, bad_open}, 8'd1);
        tick();
        chk("R3 no block", {7'd0, in_blk}, 8'd0);
        open_vld = 1; open_cond = 4'b1110; open_len = 2'd0; open_else = 3'b001;
        #1;
        chk("R3 unused else ok", {7'd0, bad_open}, 8'd0);
        tick();
        chk("R3 block started", {7'd0, in_blk}, 8'd1);
        iss_vld = 1; tick();

        // R5 breakpoint with failing condition
        flags = 4'b0000;
        open_blk(4'b0000, 2'd0, 3'd0);
        chk("R5 fail without bkpt", {7'd0, exec_ok}, 8'd0);
        iss_vld = 1; iss_bkpt = 1; #1;
        chk("R5 bkpt executes", {7'd0, exec_ok}, 8'd1);
        tick();

        // R8 opening and CBZ inside a block; R9 stall
        open_blk(4'b1010, 2'd1, 3'b001);
        open_vld = 1; open_cond = 4'b0000; open_len = 2'd0; #1;
        chk("R8 open in block", {7'd0, bad_nest}, 8'd1);
        tick();
        chk("R8 no reload", {4'd0, cur_cond}, 8'h0A);
        iss_vld = 1; iss_cbz = 1; stall = 1; #1;
        chk("R9 no flag on stall", {7'd0, bad_nest}, 8'd0);
        tick();
        chk("R9 slot held", {4'd0, cur_cond}, 8'h0A);
        iss_vld = 1; iss_cbz = 1; #1;
        chk("R8 cbz in block", {7'd0, bad_nest}, 8'd1);
        tick();
        chk("R9 advanced after stall", {4'd0, cur_cond}, 8'h0B);
        iss_vld = 1; tick();
        iss_vld = 1; iss_cbz = 1; #1;
        chk("R8 cbz outside ok", {7'd0, bad_nest}, 8'd0);
        tick();

        // R6/R7 save, bad jump, exception return
        open_blk(4'b1100, 2'd3, 3'b000);
        chk("R6 initial state", st_out, 8'hC1);
        iss_vld = 1; tick();
        saved = st_out;
        chk("R6 shifted state", saved, 8'hC2);
        st_load = 1; st_exret = 0; st_in = saved; #1;
        chk("R7 bad entry", {7'd0, bad_entry}, 8'd1);
        tick();
        chk("R7 cleared", st_out, 8'h00);
        st_load = 1; st_exret = 1; st_in = saved; stall = 1;
        tick();
        chk("R6 restored", st_out, 8'hC2);
        for (int k = 0; k < 3; k++) begin
            chk("R6 resumes", {7'd0, in_blk}, 8'd1);
            iss_vld = 1; tick();
        end
        chk("R6 ends after 3", {7'd0, in_blk}, 8'd0);

        // R10 reset mid-block
        open_blk(4'b0000, 2'd3, 3'b000);
        rst_n = 0; tick();
        rst_n = 1;
        chk("R10 reset clears", st_out, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule